// File: doc/BRIEF.md
# Manchester Line Codec

This block holds a bi-phase line encoder and a matching decoder that share one sample enable. On the transmit side, each bit handed over with a bit strobe becomes a line symbol of two equal halves. The two halves always have opposite levels, so the line changes level exactly in the middle of the bit. A one is sent low then high. A zero is sent high then low.

On the receive side, the line is sampled on every sample enable, which runs at `OSR` (default 16) times the bit rate. A local bit-phase counter sets the two decision points, at one quarter and three quarters of the bit. While the decoder is unlocked, it snaps the counter onto a transition that follows a long quiet stretch, because such a transition can only be a mid-bit one. Once locked, it moves the counter by at most one sample per early or late mid-bit transition. Transitions close to a bit boundary never move the counter.

Each decision produces a one-cycle strobe carrying the recovered bit. If the two halves are equal, the strobe also carries a code-violation flag, and that flag drops the lock indication. Lock is declared on the strobe of the eighth valid bit in a row.

Top module: `manchester_codec`

## Requirements
- R1: The first half of each transmitted bit carries the inverse of the bit and the second half carries the bit itself: a 1 is sent low-then-high, a 0 high-then-low.
- R2: The transmit line level changes only on a sample enable. A bit strobe accepted on a sample enable sets the first-half level after that clock edge.
- R3: Each half of a transmitted symbol lasts exactly OSR/2 sample enables, so the one guaranteed transition sits at mid-bit. The line idles low after reset.
- R4: The decoder issues exactly one single-cycle strobe per bit period. It takes the 1/4 sample as the first half and the 3/4 sample as the second half, and the strobe carries 1 for low-then-high and 0 for high-then-low.
- R5: When both half-bit samples are equal, the strobe carries the violation flag, and the lock indication is low in that same cycle.
- R6: The lock indication rises together with the strobe of the 8th consecutive valid bit (LOCK_BITS), and not before.
- R7: While locked, a mid-bit transition seen 1 to 3 samples early advances the phase counter by one extra sample, and one seen 1 to 3 samples late holds it for one sample. A drift of one sample per two bits, accumulating to six samples, is tracked without a violation.
- R8: Transitions falling within OSR/4 samples of a bit boundary do not move the phase counter. Long runs of identical bits, which carry a transition at every boundary, decode correctly and keep the lock.
- R9: While unlocked, a transition arriving at least 3*OSR/4 samples after the previous transition realigns the phase counter to mid-bit. Acquisition therefore works from idle followed by alternating bits that begin with 1.
- R10: During reset the line output, strobe, violation flag and lock indication are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | Sample enable, OSR per bit period |
| tx_bit_en | input | 1 | Starts a new transmit bit; honoured only with samp_en |
| tx_bit | input | 1 | Bit value to transmit |
| tx_line | output | 1 | Encoded line output |
| rx_line | input | 1 | Received line, already in the clk domain |
| rx_bit | output | 1 | Recovered bit, valid with rx_strobe |
| rx_strobe | output | 1 | One-cycle pulse per decoded bit |
| rx_violation | output | 1 | Equal half-bit samples, valid with rx_strobe |
| rx_locked | output | 1 | Decoder has seen LOCK_BITS valid bits in a row |

## Verification
A phase counter that is off by more than a quarter bit shows up at the ports within one or two bit periods. In that state one of the two decision samples falls in the wrong half, so a violation strobe appears and the lock indication falls in the same cycle. A step that fails to track drift, or one that wrongly reacts to boundary transitions, stays hidden until the accumulated error passes four samples. For that reason the delayed-loopback drift run and the all-ones and all-zeros words matter. A wrong lock count is visible as the lock indication rising on a strobe other than the eighth valid one after acquisition or after a violation.

// File: rtl/man_pkg.sv
// Shared types for the Manchester codec.
// Assumes the oversampling ratio is a power of two and at least 8.
package man_pkg;

    // Where an observed transition falls relative to the expected mid-bit point
    typedef enum logic [1:0] {
        RGN_BOUNDARY,
        RGN_EARLY,
        RGN_ON_TIME,
        RGN_LATE
    } mid_rgn_e;

    // Classify a local phase value at which a line transition was seen
    function automatic mid_rgn_e classify_phase(input int ph, input int osr);
        if (ph == osr / 2)                    return RGN_ON_TIME;
        if (ph > osr / 4 && ph < osr / 2)     return RGN_EARLY;
        if (ph > osr / 2 && ph < 3 * osr / 4) return RGN_LATE;
        return RGN_BOUNDARY;
    endfunction

endpackage

// File: rtl/man_encoder.sv
// Bi-phase line encoder.
// Emits the inverted bit for the first half of a bit period and the true bit
// for the second half, so every bit carries one transition at mid-bit.
// Assumes bit_en is pulsed together with samp_en once every OSR sample enables.
module man_encoder #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic bit_en,
    input  logic bit_in,
    output logic line_out
);
    localparam int HALF  = OSR / 2;
    localparam int CNT_W = $clog2(OSR + 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             held_bit;

    // Load a new symbol on bit_en, swap to the second half after HALF ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            held_bit <= 1'b0;
            tick_cnt <= CNT_W'(OSR);
        end else if (samp_en) begin
            if (bit_en) begin
                held_bit <= bit_in;
                line_out <= ~bit_in;
                tick_cnt <= CNT_W'(1);
            end else begin
                if (tick_cnt == CNT_W'(HALF)) line_out <= held_bit;
                if (tick_cnt != CNT_W'(OSR))  tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R1: first half of a new symbol is the inverse of the accepted bit
    a_r1_first_half_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && bit_en) |=> (line_out == !$past(bit_in)));

    // R2: the line never moves between sample enables
    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(line_out));

endmodule

// File: rtl/man_phase_track.sv
// Bit-phase tracking loop for the Manchester decoder.
// Keeps a local phase counter (0..OSR-1, mid-bit expected at OSR/2), detects
// line transitions on sample enables, and corrects the counter:
//   unlocked: a transition after a long quiet gap snaps the phase to mid-bit;
//   locked:   an early/late mid-bit transition shifts the phase by one sample.
// Transitions near the bit boundary are left alone.
// Assumes line_in is already synchronous to clk.
module man_phase_track
    import man_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   samp_en,
    input  logic                   line_in,
    input  logic                   locked,
    output logic [$clog2(OSR)-1:0] phase,
    output logic                   line_prev,
    output logic                   realign
);
    localparam int PH_W    = $clog2(OSR);
    localparam int MID     = OSR / 2;
    localparam int LONG    = 3 * OSR / 4;
    localparam int GAP_MAX = 2 * OSR - 1;
    localparam int GAP_W   = $clog2(2 * OSR);

    logic [GAP_W-1:0] gap;
    logic             edge_now;
    mid_rgn_e         rgn;

    // Transition detect, phase classification and acquisition decision
    always_comb begin
        edge_now = samp_en && (line_in != line_prev);
        rgn      = classify_phase(int'(phase), OSR);
        realign  = edge_now && !locked && (gap >= GAP_W'(LONG));
    end

    // Advance, nudge or snap the phase counter; track the quiet gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            line_prev <= 1'b0;
            gap       <= GAP_W'(GAP_MAX);
        end else if (samp_en) begin
            line_prev <= line_in;
            if (edge_now)                     gap <= '0;
            else if (gap != GAP_W'(GAP_MAX))  gap <= gap + 1'b1;

            if (realign)
                phase <= PH_W'(MID + 1);
            else if (edge_now && locked && rgn == RGN_EARLY)
                phase <= phase + PH_W'(2);
            else if (edge_now && locked && rgn == RGN_LATE)
                phase <= phase;
            else
                phase <= phase + 1'b1;
        end
    end

    // R7: while locked, one sample enable moves the phase by 0, 1 or 2 only
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && locked) |=> (PH_W'(phase - $past(phase)) <= PH_W'(2)));

    // R8: a boundary-zone transition while locked leaves the normal advance
    a_r8_boundary_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && locked && rgn == RGN_BOUNDARY)
            |=> (phase == PH_W'($past(phase) + 1'b1)));

    // R9: realignment only happens while unlocked
    a_r9_realign_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> !locked);

endmodule

// File: rtl/man_bit_slicer.sv
// Decision stage of the Manchester decoder.
// Captures the first-half level at phase OSR/4 and decides at phase 3*OSR/4:
// a differing pair gives a data bit (second-half level), an equal pair gives
// a code violation. Counts consecutive valid bits to declare lock.
// Assumes phase/realign come from man_phase_track on the same samp_en.
module man_bit_slicer #(
    parameter int OSR       = 16,
    parameter int LOCK_BITS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   samp_en,
    input  logic                   line_in,
    input  logic                   line_prev,
    input  logic [$clog2(OSR)-1:0] phase,
    input  logic                   realign,
    output logic                   bit_out,
    output logic                   strobe,
    output logic                   violation,
    output logic                   locked
);
    localparam int PH_W  = $clog2(OSR);
    localparam int Q1    = OSR / 4;
    localparam int Q3    = 3 * OSR / 4;
    localparam int LCK_W = $clog2(LOCK_BITS + 1);

    logic             first_half;
    logic [LCK_W-1:0] run_cnt;

    // Sample the first half, decide at three quarters, maintain lock count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_half <= 1'b0;
            bit_out    <= 1'b0;
            strobe     <= 1'b0;
            violation  <= 1'b0;
            run_cnt    <= '0;
            locked     <= 1'b0;
        end else begin
            strobe    <= 1'b0;
            violation <= 1'b0;
            if (samp_en) begin
                if (realign)
                    first_half <= line_prev;
                else if (phase == PH_W'(Q1))
                    first_half <= line_in;

                if (phase == PH_W'(Q3) && !realign) begin
                    strobe  <= 1'b1;
                    bit_out <= line_in;
                    if (line_in == first_half) begin
                        violation <= 1'b1;
                        run_cnt   <= '0;
                        locked    <= 1'b0;
                    end else begin
                        if (run_cnt != LCK_W'(LOCK_BITS)) run_cnt <= run_cnt + 1'b1;
                        if (run_cnt >= LCK_W'(LOCK_BITS - 1)) locked <= 1'b1;
                    end
                end
            end
        end
    end

    // R4: a strobe never lasts more than one cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R5: a violation is reported only with a strobe, and lock is low with it
    a_r5_violation_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (strobe && !locked));

    // R6: lock rises only together with a valid strobe
    a_r6_lock_with_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (strobe && !violation));

endmodule

// File: rtl/manchester_codec.sv
// Manchester line codec top: encoder plus oversampling decoder with a
// phase-correcting loop and lock indication.
// Assumes samp_en runs at OSR times the bit rate, OSR is a power of two (>= 8),
// and rx_line is already synchronous to clk.
module manchester_codec #(
    parameter int OSR       = 16,
    parameter int LOCK_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic tx_bit_en,
    input  logic tx_bit,
    output logic tx_line,
    input  logic rx_line,
    output logic rx_bit,
    output logic rx_strobe,
    output logic rx_violation,
    output logic rx_locked
);
    localparam int PH_W = $clog2(OSR);

    logic [PH_W-1:0] phase;
    logic            line_prev;
    logic            realign;

    man_encoder #(.OSR(OSR)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .bit_en   (tx_bit_en),
        .bit_in   (tx_bit),
        .line_out (tx_line)
    );

    man_phase_track #(.OSR(OSR)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en   (samp_en),
        .line_in   (rx_line),
        .locked    (rx_locked),
        .phase     (phase),
        .line_prev (line_prev),
        .realign   (realign)
    );

    man_bit_slicer #(.OSR(OSR), .LOCK_BITS(LOCK_BITS)) u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en   (samp_en),
        .line_in   (rx_line),
        .line_prev (line_prev),
        .phase     (phase),
        .realign   (realign),
        .bit_out   (rx_bit),
        .strobe    (rx_strobe),
        .violation (rx_violation),
        .locked    (rx_locked)
    );

endmodule

// File: tb/test_manchester_codec.sv
`timescale 1ns/1ps
// Loopback bench: encoder output goes through a variable delay line (with an
// optional constant-level override) into the decoder.
module test_manchester_codec;
    localparam int NV = 8;
    localparam logic [15:0] VEC_WORD [NV] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h1234,
                                              16'hF0F0, 16'h8001, 16'h5555, 16'hCCCC};
    // 1 = word made of one repeated value (boundary transitions every bit, R8)
    localparam logic VEC_SAME [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0;
    logic tx_bit_en = 1'b0;
    logic tx_bit = 1'b0;
    logic tx_line;
    logic rx_line;
    logic rx_bit, rx_strobe, rx_violation, rx_locked;

    logic [31:0] dly = '0;
    int   dsel = 3;
    logic inj = 1'b0;
    int   cyc = 0;

    int n_chk = 0;
    int n_err = 0;

    logic tx_val  [512];
    logic tx_inj  [512];
    int   tx_time [512];
    int   n_tx = 0;

    int    mp = 0;
    int    run = 0;
    int    lock_run = 0;
    int    lock_events = 0;
    int    n_viol = 0;
    logic  seen_locked = 1'b0;
    logic  chk_en = 1'b0;
    string cur_req = "R4";

    always #2.5 clk = ~clk;

    assign rx_line = dly[dsel];

    manchester_codec i_manchester_codec (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_en      (samp_en),
        .tx_bit_en    (tx_bit_en),
        .tx_bit       (tx_bit),
        .tx_line      (tx_line),
        .rx_line      (rx_line),
        .rx_bit       (rx_bit),
        .rx_strobe    (rx_strobe),
        .rx_violation (rx_violation),
        .rx_locked    (rx_locked)
    );

    // Sample enable every second clock, cycle counter, delay line
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            dly <= {dly[30:0], inj ? 1'b1 : tx_line};
            #1 samp_en = ~samp_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    // Send one bit (called at a negedge); checks the encoder waveform (R1, R2, R3)
    task automatic send_bit(input logic b, input logic inj_slot, input int shift);
        int k_sh;
        while (!samp_en) @(negedge clk);
        tx_bit_en = 1'b1;
        tx_bit    = b;
        inj       = inj_slot;
        tx_val[n_tx]  = b;
        tx_inj[n_tx]  = inj_slot;
        tx_time[n_tx] = cyc;
        n_tx++;
        k_sh = ((dsel + 10) % 16) + 1;
        for (int k = 1; k <= 32; k++) begin
            @(negedge clk);
            if (k == 1) tx_bit_en = 1'b0;
            if (k == 8)  chk(tx_line == !b, b ? "R1 first half of 1" : "R1 first half of 0", tx_line, !b);
            if (k == 24) chk(tx_line == b,  b ? "R1 second half of 1" : "R1 second half of 0", tx_line, b);
            if (k == 1 || k == 16) chk(tx_line == !b, "R3 first half width", tx_line, !b);
            if (k == 17 || k == 32) chk(tx_line == b, "R3 second half width", tx_line, b);
            if (k == 2 && n_tx == 2) chk(tx_line == !b, "R2 level after accepted strobe", tx_line, !b);
            if (shift != 0 && k == k_sh) dsel += shift;
        end
        inj = 1'b0;
    endtask

    // Decoder monitor and scoreboard (R4, R5)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_strobe) begin
                while (mp + 1 < n_tx && tx_time[mp + 1] + 20 <= cyc) mp++;
                if (rx_violation) begin run = 0; n_viol++; end
                else run++;
                if (chk_en) begin
                    chk(rx_violation == tx_inj[mp], "R5 violation flag", rx_violation, tx_inj[mp]);
                    if (!tx_inj[mp] && !rx_violation)
                        chk(rx_bit == tx_val[mp], cur_req, rx_bit, tx_val[mp]);
                    if (rx_violation) chk(!rx_locked, "R5 lock cleared", rx_locked, 0);
                end
                if (rx_locked && !seen_locked) begin
                    lock_run = run;
                    lock_events++;
                end
            end
            seen_locked = rx_locked;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Main sequence
    initial begin
        int v0;
        // R10: reset state
        repeat (5) @(negedge clk);
        chk(tx_line == 1'b0,      "R10 tx_line in reset", tx_line, 0);
        chk(rx_strobe == 1'b0,    "R10 strobe in reset", rx_strobe, 0);
        chk(rx_violation == 1'b0, "R10 violation in reset", rx_violation, 0);
        chk(rx_locked == 1'b0,    "R10 lock in reset", rx_locked, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 acquisition from idle with alternating bits starting at 1; R6 lock count
        for (int i = 0; i < 12; i++) send_bit(i % 2 == 0, 1'b0, 0);
        chk(rx_locked == 1'b1, "R9 lock acquired", rx_locked, 1);
        chk(lock_run == 8, "R6 lock on 8th valid bit", lock_run, 8);
        chk(lock_events == 1, "R6 single lock rise", lock_events, 1);

        // Vector table: words sent LSB first, each decoded bit must match (R4, R8)
        chk_en = 1'b1;
        v0 = n_viol;
        for (int w = 0; w < NV; w++) begin
            cur_req = VEC_SAME[w] ? "R8 repeated-value word bit" : "R4 decoded bit";
            for (int b = 0; b < 16; b++) send_bit(VEC_WORD[w][b], 1'b0, 0);
        end
        chk(rx_locked == 1'b1, "R8 lock kept through repeated values", rx_locked, 1);
        chk(n_viol == v0, "R8 no violations", n_viol - v0, 0);

        // R7: drift of one sample every two bits, six samples in total
        cur_req = "R7 bit under drift";
        v0 = n_viol;
        for (int s = 0; s < 6; s++) begin
            send_bit(1'b1, 1'b0, 2);
            send_bit(1'b0, 1'b0, 0);
        end
        for (int i = 0; i < 8; i++) send_bit(i % 3 == 0, 1'b0, 0);
        chk(n_viol == v0, "R7 no violation under drift", n_viol - v0, 0);
        chk(rx_locked == 1'b1, "R7 lock kept under drift", rx_locked, 1);

        // R5: one slot forced to a constant level, then relock (R6)
        cur_req = "R5 bit around violation";
        v0 = n_viol;
        send_bit(1'b1, 1'b0, 0);
        send_bit(1'b1, 1'b1, 0);
        for (int i = 0; i < 11; i++) send_bit(i % 2 == 1, 1'b0, 0);
        chk(n_viol == v0 + 1, "R5 exactly one violation", n_viol - v0, 1);
        chk(lock_events == 2, "R6 relock after violation", lock_events, 2);
        chk(lock_run == 8, "R6 relock on 8th valid bit", lock_run, 8);
        chk(rx_locked == 1'b1, "R6 locked at end", rx_locked, 1);

        // R10: reset mid-stream clears outputs
        chk_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(tx_line == 1'b0,   "R10 tx_line after reset", tx_line, 0);
        chk(rx_locked == 1'b0, "R10 lock after reset", rx_locked, 0);
        chk(rx_strobe == 1'b0, "R10 strobe after reset", rx_strobe, 0);

        summary();
        $finish;
    end

endmodule